// File: doc/BRIEF.md
# Power-of-Two Card Clock Divider

This block derives the memory-card bus clock from the peripheral clock. A 4-bit divide code picks a power-of-two ratio. Code n gives a ratio of 2^(n+1), so the slowest ratio is /512. The all-ones code passes the peripheral clock through undivided, but only on parts where a bypass-support strap is tied high. A separate enable input gates the card clock. While the enable is off, the output stays low.

The divide code, the enable and the strap come from a register that lives in another clock domain. They pass through a synchronizer before they are used. The block takes a new setting only at the moment the divided output would next rise, that is, at the end of a complete low phase. As a result, a reprogrammed ratio or an enable change never produces a shortened high or low phase.

Alongside the clock, the block drives a strobe that is one peripheral-clock cycle wide. The strobe marks the first cycle of every high phase, so downstream timeout counters can count card-clock periods without sampling the card clock themselves. The strobe stays high continuously while the bypass is active.

Top module: `card_clk_div`

## Requirements
- R1: While reset is asserted and after reset is released, with no enable yet seen, the card clock and the strobe are low.
- R2: Divide code n, for n from 0 to 8, produces a card clock with a period of 2^(n+1) peripheral cycles. The high phase and the low phase are each 2^n cycles long.
- R3: Divide codes 9 to 14 behave as code 8, giving /512.
- R4: Code 15 with the strap at 1 routes the peripheral clock straight to the card clock. The strap has no effect on codes 0 to 14.
- R5: Code 15 with the strap at 0 behaves as code 8, giving /512.
- R6: With the enable at 0, the card clock is held low and the strobe never fires.
- R7: A new code or enable value is adopted only at the end of a full low phase. A change made during a high phase lets the current period finish at the old ratio.
- R8: The strobe is high for exactly the first peripheral cycle of each divided high phase, and is low at all other times in divided mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_code_i | input | 4 | Divide code from the clock control register |
| clk_en_i | input | 1 | Card clock enable from the clock control register |
| byp_ok_i | input | 1 | Strap that permits the undivided bypass code |
| card_clk_o | output | 1 | Card bus clock |
| rise_o | output | 1 | One-cycle strobe at each card clock rising edge |

## Verification
Two things can happen on the same edge: the adoption of new settings and the start of a high phase with its strobe. Both occur on the edge that ends a low phase. The bench provokes this coincidence by changing the code partway through a /512 high phase. It then measures the whole run of high and low samples that follows. The test passes only if the old period completes exactly and the very next high phase, with its strobe, already has the new width. A second case disables the clock in the middle of a high phase. In that case the bench expects the high phase to finish at full width and no further strobe to appear.

// File: rtl/card_clk_pkg.sv
package card_clk_pkg;
  localparam int CODE_W = 4;
  localparam int MAX_SH = 8;
  localparam int SH_W   = $clog2(MAX_SH + 1);
  localparam int CNT_W  = MAX_SH;

  typedef struct packed {
    logic            en;
    logic            byp;
    logic [SH_W-1:0] sh;   // half period = 2**sh cycles
  } clk_cfg_t;
endpackage

// File: rtl/card_clk_sync.sv
module card_clk_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/card_clk_decode.sv
module card_clk_decode
  import card_clk_pkg::*;
#(
  parameter int CODE_SZ = CODE_W,
  parameter int SH_MAX  = MAX_SH
) (
  input  logic [CODE_SZ-1:0] code_i,
  input  logic               en_i,
  input  logic               byp_ok_i,
  output clk_cfg_t           cfg_o
);
  localparam logic [CODE_SZ-1:0] BYP_CODE = '1;

  always_comb begin
    cfg_o     = '0;
    cfg_o.en  = en_i;
    cfg_o.byp = en_i && byp_ok_i && (code_i == BYP_CODE);
    if (cfg_o.byp)
      cfg_o.sh = '0;
    else if (int'(code_i) > SH_MAX)
      cfg_o.sh = SH_W'(SH_MAX);   // oversize and unstrapped bypass saturate
    else
      cfg_o.sh = SH_W'(code_i);
  end
endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen
  import card_clk_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  clk_cfg_t      cfg_i,
  output logic          card_clk_o,
  output logic          rise_o,
  output clk_cfg_t      act_o,
  output logic          div_o,
  output logic [CW-1:0] cnt_o
);
  clk_cfg_t      act_q;
  logic [CW-1:0] cnt_q, mask;
  logic          div_q, rise_q, load;

  always_comb begin
    for (int i = 0; i < CW; i++) mask[i] = (i < int'(act_q.sh));
  end

  // settings are only taken where a high phase would begin
  assign load = !act_q.en || act_q.byp || (!div_q && (cnt_q == mask));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= '0;
      cnt_q  <= '0;
      div_q  <= 1'b0;
      rise_q <= 1'b0;
    end else if (load) begin
      act_q  <= cfg_i;
      cnt_q  <= '0;
      div_q  <= cfg_i.en;
      rise_q <= cfg_i.en;
    end else begin
      rise_q <= 1'b0;
      if (cnt_q == mask) begin
        cnt_q <= '0;
        div_q <= ~div_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign card_clk_o = act_q.byp ? clk_i : div_q;
  assign rise_o     = rise_q;
  assign act_o      = act_q;
  assign div_o      = div_q;
  assign cnt_o      = cnt_q;
endmodule

// File: rtl/card_clk_div.sv
module card_clk_div
  import card_clk_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CODE_SZ     = CODE_W,
  parameter int SH_MAX      = MAX_SH,
  localparam int CW         = SH_MAX
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CODE_SZ-1:0] div_code_i,
  input  logic               clk_en_i,
  input  logic               byp_ok_i,
  output logic               card_clk_o,
  output logic               rise_o
);
  localparam int SW = CODE_SZ + 2;

  logic [SW-1:0]      sync_q;
  logic [CODE_SZ-1:0] code_s;
  logic               en_s, byp_ok_s;
  clk_cfg_t           cfg, act_w;
  logic               div_w;
  logic [CW-1:0]      cnt_w;
  logic               act_en_w, act_byp_w;
  logic [SH_W-1:0]    act_sh_w;

  card_clk_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({clk_en_i, byp_ok_i, div_code_i}),
    .q_o   (sync_q)
  );

  assign {en_s, byp_ok_s, code_s} = sync_q;

  card_clk_decode #(.CODE_SZ(CODE_SZ), .SH_MAX(SH_MAX)) u_dec (
    .code_i  (code_s),
    .en_i    (en_s),
    .byp_ok_i(byp_ok_s),
    .cfg_o   (cfg)
  );

  card_clk_gen #(.CW(CW)) u_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_i     (cfg),
    .card_clk_o(card_clk_o),
    .rise_o    (rise_o),
    .act_o     (act_w),
    .div_o     (div_w),
    .cnt_o     (cnt_w)
  );

  assign act_en_w  = act_w.en;
  assign act_byp_w = act_w.byp;
  assign act_sh_w  = act_w.sh;
endmodule

// File: rtl/card_clk_div_chk.sv
module card_clk_div_chk #(
  parameter int CW   = 8,
  parameter int SH_W = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            card_clk_o,
  input logic            rise_o,
  input logic            act_en_i,
  input logic            act_byp_i,
  input logic [SH_W-1:0] act_sh_i,
  input logic            div_i,
  input logic [CW-1:0]   cnt_i
);
  AST_OFF_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_en_i |-> (!card_clk_o && !rise_o)); // R6

  AST_HIGH_CFG_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_i && !act_byp_i) |=> ($stable(act_sh_i) && $stable(act_en_i))); // R7

  AST_CNT_IN_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i >> act_sh_i) == '0); // R2

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o && !act_byp_i) |=> !rise_o); // R8

  AST_RISE_ON_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> (div_i || act_byp_i)); // R8

  AST_BYP_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_byp_i |-> act_en_i); // R4
endmodule

bind card_clk_div card_clk_div_chk #(.CW(CW), .SH_W(card_clk_pkg::SH_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .card_clk_o(card_clk_o),
  .rise_o    (rise_o),
  .act_en_i  (act_en_w),
  .act_byp_i (act_byp_w),
  .act_sh_i  (act_sh_w),
  .div_i     (div_w),
  .cnt_i     (cnt_w)
);

// File: tb/card_clk_div_test.sv
`timescale 1ns/1ps
module card_clk_div_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] div_code_i = 4'd0;
  logic       clk_en_i = 1'b0;
  logic       byp_ok_i = 1'b0;
  logic       card_clk_o, rise_o;

  int n_chk = 0, n_fail = 0;
  bit mon_busy = 1'b0;
  bit done = 1'b0;

  typedef struct {int kind; int half; string req;} exp_t; // kind 0 divided, 1 bypass, 2 off
  exp_t exp_q[$];

  always #4 clk_i = ~clk_i;

  card_clk_div uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_code_i(div_code_i),
    .clk_en_i(clk_en_i), .byp_ok_i(byp_ok_i),
    .card_clk_o(card_clk_o), .rise_o(rise_o)
  );

  task automatic tick();
    @(posedge clk_i); #2;
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_high(output int hi, output int rises);
    hi = 0; rises = 0;
    while (card_clk_o && hi < 2000) begin
      if (rise_o) rises++;
      hi++; tick();
    end
  endtask

  task automatic run_low(output int lo, output int rises);
    lo = 0; rises = 0;
    while (!card_clk_o && lo < 2000) begin
      if (rise_o) rises++;
      lo++; tick();
    end
  endtask

  task automatic wait_rise();
    for (int n = 0; n < 2000 && !rise_o; n++) tick();
  endtask

  task automatic drive(int code, bit en, bit strap, int kind, int half, string req);
    tick();
    div_code_i = 4'(code); clk_en_i = en; byp_ok_i = strap;
    repeat (1100) tick();
    exp_q.push_back('{kind, half, req});
    wait (exp_q.size() == 0 && !mon_busy);
  endtask

  // monitor: pops expectations and measures the card clock
  initial begin
    exp_t e;
    int hi, lo, r1, r2, bad;
    forever begin
      wait (exp_q.size() > 0);
      mon_busy = 1'b1;
      e = exp_q.pop_front();
      if (e.kind == 0) begin
        wait_rise();
        for (int p = 0; p < 2; p++) begin
          run_high(hi, r1);
          run_low(lo, r2);
          chk(hi == e.half, {e.req, " high phase"}, hi, e.half);
          chk(lo == e.half, {e.req, " low phase"}, lo, e.half);
          chk(r1 == 1 && r2 == 0, {e.req, " R8 strobe count"}, r1 + r2, 1);
        end
      end else if (e.kind == 1) begin
        bad = 0;
        for (int c = 0; c < 16; c++) begin
          tick();
          if (!card_clk_o || !rise_o) bad++;
          @(negedge clk_i); #2;
          if (card_clk_o) bad++;
        end
        chk(bad == 0, {e.req, " bypass follows clock"}, bad, 0);
      end else begin
        bad = 0;
        for (int c = 0; c < 600; c++) begin
          if (card_clk_o || rise_o) bad++;
          tick();
        end
        chk(bad == 0, {e.req, " held low"}, bad, 0);
      end
      mon_busy = 1'b0;
    end
  end

  initial begin
    int hi, lo, r1, r2, bad;
    div_code_i = 4'd1; clk_en_i = 1'b1; byp_ok_i = 1'b0;
    repeat (5) tick();
    chk(!card_clk_o && !rise_o, "R1 during reset", int'(card_clk_o) + int'(rise_o), 0);
    clk_en_i = 1'b0;
    rst_ni = 1'b1;
    repeat (4) tick();
    chk(!card_clk_o && !rise_o, "R1 after release", int'(card_clk_o) + int'(rise_o), 0);

    drive(0,  1, 0, 0, 1,   "R2 code0");
    drive(1,  1, 0, 0, 2,   "R2 code1");
    drive(3,  1, 0, 0, 8,   "R2 code3");
    drive(7,  1, 1, 0, 128, "R2 R4 code7 strap1");
    drive(8,  1, 0, 0, 256, "R2 code8");
    drive(10, 1, 0, 0, 256, "R3 code10");
    drive(14, 1, 1, 0, 256, "R3 code14");
    drive(15, 1, 0, 0, 256, "R5 code15 no strap");
    drive(15, 1, 1, 1, 0,   "R4 bypass");
    drive(1,  1, 1, 0, 2,   "R4 leave bypass");
    drive(2,  0, 0, 2, 0,   "R6 disabled");

    // R7: code change in mid high phase, old period must finish
    drive(8, 1, 0, 0, 256, "R7 setup");
    wait_rise();
    hi = 0;
    while (card_clk_o && hi < 2000) begin
      if (hi == 10) div_code_i = 4'd0;
      hi++; tick();
    end
    run_low(lo, r2);
    chk(hi == 256, "R7 old high kept", hi, 256);
    chk(lo == 256, "R7 old low kept", lo, 256);
    chk(rise_o == 1'b1, "R7 R8 strobe with new ratio", int'(rise_o), 1);
    run_high(hi, r1);
    chk(hi == 1, "R7 new high", hi, 1);

    // R7 and R6: disable in mid high phase
    drive(3, 1, 0, 0, 8, "R7 setup2");
    wait_rise();
    hi = 0;
    while (card_clk_o && hi < 2000) begin
      if (hi == 2) clk_en_i = 1'b0;
      hi++; tick();
    end
    chk(hi == 8, "R7 high completes before off", hi, 8);
    bad = 0;
    for (int c = 0; c < 40; c++) begin
      if (card_clk_o || rise_o) bad++;
      tick();
    end
    chk(bad == 0, "R6 stays low after off", bad, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule